// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Maskable Interrupt

This block is a serial port that software drives through six word-aligned registers in a 32-byte window on a simple 32-bit bus. It holds one character waiting to be sent and one received character. Each character travels as one start bit, eight data bits sent least significant bit first and one stop bit, with no parity. The bit period is a count of system clocks that software writes to the divisor register.

Every event lands in a status word. A control word with the same bit layout selects which status bits may raise the single level interrupt line. The control word also carries a bit that holds the serial output low (a line break) and a bit that drives the RTS output. The CTS input is synchronised, and its level and any change in it show up in status. Error flags stay set until software writes the status register. Parity is not implemented, so its flag always reads zero.

Top module: `mmio_uart`

Register word index is `bus_addr[4:2]`: 0 receive data, 1 transmit data, 2 status, 3 control, 4 divisor, 5 end-of-packet. Status bits: 0 parity error, 1 framing error, 2 break seen, 3 receive overrun, 4 transmit overrun, 5 transmitter fully idle, 6 transmit ready, 7 receive ready, 8 exception, 10 CTS changed, 11 CTS level, 12 end-of-packet. Control bits 0 to 8, 10 and 12 enable the interrupt for the status bit in the same position. Control bit 9 forces a break and control bit 11 drives RTS.

## Requirements
- R1: After reset the status register reads 0x060 (transmit ready and transmitter idle only), control reads 0, the divisor reads its reset parameter value, ser_tx is 1, and irq and rts_out are 0.
- R2: A write to transmit data sends a frame on ser_tx: a low start bit, data bits 0 to 7, then a high stop bit, each lasting exactly the divisor number of clocks.
- R3: In the first cycle after an accepted transmit write, status bits 6 and 5 both read 0. Once the character moves into the idle shifter, bit 6 reads 1. Bit 5 reads 1 only when no character is held and none is being shifted.
- R4: A transmit write while bit 6 is 0 sets bits 4 and 8. The written character is discarded and never appears on ser_tx.
- R5: A frame received on ser_rx makes its data byte readable at receive data and sets status bit 7.
- R6: A read of receive data clears status bit 7.
- R7: If a frame completes while bit 7 is still set, bits 3 and 8 are set and receive data holds the newer byte.
- R8: A stop bit sampled low sets bits 1 and 8, and the byte is still delivered with bit 7.
- R9: A frame whose data and stop bit are all zero sets bit 2 as well as bits 1 and 8.
- R10: Any write to the status register clears bits 1, 2, 3, 4 and 10, and bit 8 with them. Bits 5, 6, 7 and 11 are left unchanged.
- R11: irq is 1 exactly while some status bit in positions 0 to 8, 10 or 12 is set together with the control bit in the same position. Control bits 9 and 11 never raise irq.
- R12: While control bit 9 is set, ser_tx is 0. Clearing the bit returns an idle line to 1.
- R13: rts_out follows control bit 11. Status bit 11 follows cts_in after synchronisation, and any change of that level sets status bit 10.
- R14: The divisor register reads back what was written and sets the bit period of both directions. The end-of-packet register keeps an 8-bit value, while status bits 0 and 12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address inside the 32-byte window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; read side effects apply at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq | output | 1 | Level interrupt request |
| ser_rx | input | 1 | Serial receive line, idle high |
| ser_tx | output | 1 | Serial transmit line, idle high |
| cts_in | input | 1 | Clear-to-send input |
| rts_out | output | 1 | Request-to-send output |

## Verification
A wrong bit counter or divisor compare in either direction shows up within one character time. On the transmit side, the mid-bit samples of ser_tx come out wrong. On the receive side, the received byte differs when every byte value is swept. A wrong holding-register state shows up as transmit-ready, idle or overrun flags that are wrong in the cycle right after a write, or as a discarded character that still appears on the line. Sticky-flag and mask faults show on the next status read or directly on irq, one cycle after the bus access that should have changed them.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int ST_W = 13;

    localparam logic [2:0] RG_RXD  = 3'd0;
    localparam logic [2:0] RG_TXD  = 3'd1;
    localparam logic [2:0] RG_STAT = 3'd2;
    localparam logic [2:0] RG_CTRL = 3'd3;
    localparam logic [2:0] RG_DIV  = 3'd4;
    localparam logic [2:0] RG_EOP  = 3'd5;

    localparam int SB_PE   = 0;
    localparam int SB_FE   = 1;
    localparam int SB_BRK  = 2;
    localparam int SB_ROE  = 3;
    localparam int SB_TOE  = 4;
    localparam int SB_TMT  = 5;
    localparam int SB_TRDY = 6;
    localparam int SB_RRDY = 7;
    localparam int SB_EXC  = 8;
    localparam int CB_TXBRK = 9;
    localparam int SB_DCTS = 10;
    localparam int SB_CTS  = 11;
    localparam int CB_RTS  = 11;
    localparam int SB_EOP  = 12;

    // control positions that act as interrupt enables: 0..8, 10, 12
    localparam logic [ST_W-1:0] IRQ_EN_MASK = 13'h15FF;

    typedef struct packed {
        logic [7:0] data;
        logic       stop_low;
        logic       all_zero;
    } rx_frame_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI
    } rx_state_e;

    function automatic logic [ST_W-1:0] irq_terms(input logic [ST_W-1:0] st,
                                                  input logic [ST_W-1:0] ctl);
        return st & ctl & IRQ_EN_MASK;
    endfunction
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  logic [7:0]       load_data,
    input  logic             force_brk,
    output logic             trdy,
    output logic             tmt,
    output logic             line
);
    localparam int FRAME_BITS = 10;
    localparam int BN_W = $clog2(FRAME_BITS);

    logic                  hold_v;
    logic [7:0]            hold_d;
    logic                  busy;
    logic [FRAME_BITS-1:0] sh;
    logic [BN_W-1:0]       bitn;
    logic [DIV_W-1:0]      cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_d <= '0;
            busy   <= 1'b0;
            sh     <= '1;
            bitn   <= '0;
            cnt    <= '0;
        end else begin
            if (busy) begin
                if (cnt == div - 1'b1) begin
                    cnt <= '0;
                    sh  <= {1'b1, sh[FRAME_BITS-1:1]};
                    if (bitn == BN_W'(FRAME_BITS - 1)) begin
                        busy <= 1'b0;
                        bitn <= '0;
                    end else begin
                        bitn <= bitn + 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (hold_v) begin
                busy   <= 1'b1;
                sh     <= {1'b1, hold_d, 1'b0};
                hold_v <= 1'b0;
                cnt    <= '0;
                bitn   <= '0;
            end
            if (load) begin
                hold_v <= 1'b1;
                hold_d <= load_data;
            end
        end
    end

    assign trdy = !hold_v;
    assign tmt  = !hold_v && !busy;
    assign line = force_brk ? 1'b0 : (busy ? sh[0] : 1'b1);

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !force_brk) |-> !line); // R2
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             line,
    output logic             done,
    output rx_frame_t        frame
);
    rx_state_e        state;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       idx;
    logic [7:0]       sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!line) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == (div >> 1)) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == div - 1'b1) begin
                        cnt <= '0;
                        sh  <= {line, sh[7:1]};
                        idx <= idx + 1'b1;
                        if (idx == 3'd7) state <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == div - 1'b1) begin
                        cnt            <= '0;
                        done           <= 1'b1;
                        frame.data     <= sh;
                        frame.stop_low <= !line;
                        frame.all_zero <= !line && (sh == 8'h00);
                        state          <= line ? RX_IDLE : RX_WAITHI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (line) state <= RX_IDLE;
                end
            endcase
        end
    end

    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import sio_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 16,
    parameter int EOP_W     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        ser_rx,
    output logic        ser_tx,
    input  logic        cts_in,
    output logic        rts_out
);
    logic [2:0]       word;
    logic [ST_W-1:0]  ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [EOP_W-1:0] eop_q;
    logic [7:0]       rx_data_q;
    logic fe_q, brk_q, roe_q, toe_q, rrdy_q, dcts_q, cts_prev;
    logic rx_s, cts_s;
    logic trdy, tmt, rx_done;
    rx_frame_t rx_frame;
    logic [ST_W-1:0] status;
    logic wr_txd, wr_stat, rd_rxd;
    logic unused_bits;

    assign word        = bus_addr[4:2];
    assign wr_txd      = bus_wr && (word == RG_TXD);
    assign wr_stat     = bus_wr && (word == RG_STAT);
    assign rd_rxd      = bus_rd && (word == RG_RXD);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    sio_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst(rst), .d({ser_rx, cts_in}), .q({rx_s, cts_s})
    );

    sio_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst(rst), .div(div_q),
        .load(wr_txd && trdy), .load_data(bus_wdata[7:0]),
        .force_brk(ctrl_q[CB_TXBRK]),
        .trdy(trdy), .tmt(tmt), .line(ser_tx)
    );

    sio_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst(rst), .div(div_q), .line(rx_s),
        .done(rx_done), .frame(rx_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            div_q     <= DIV_W'(DIV_RESET);
            eop_q     <= '0;
            rx_data_q <= '0;
            fe_q      <= 1'b0;
            brk_q     <= 1'b0;
            roe_q     <= 1'b0;
            toe_q     <= 1'b0;
            rrdy_q    <= 1'b0;
            dcts_q    <= 1'b0;
            cts_prev  <= 1'b0;
        end else begin
            cts_prev <= cts_s;
            if (bus_wr && word == RG_CTRL) ctrl_q <= bus_wdata[ST_W-1:0];
            if (bus_wr && word == RG_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
            if (bus_wr && word == RG_EOP)  eop_q  <= bus_wdata[EOP_W-1:0];
            if (wr_stat) begin
                fe_q   <= 1'b0;
                brk_q  <= 1'b0;
                roe_q  <= 1'b0;
                toe_q  <= 1'b0;
                dcts_q <= 1'b0;
            end
            if (rd_rxd) rrdy_q <= 1'b0;
            if (wr_txd && !trdy) toe_q <= 1'b1;
            if (cts_s != cts_prev) dcts_q <= 1'b1;
            if (rx_done) begin
                rx_data_q <= rx_frame.data;
                rrdy_q    <= 1'b1;
                if (rrdy_q && !rd_rxd) roe_q <= 1'b1;
                if (rx_frame.stop_low) fe_q  <= 1'b1;
                if (rx_frame.all_zero) brk_q <= 1'b1;
            end
        end
    end

    always_comb begin
        status           = '0;
        status[SB_PE]    = 1'b0;
        status[SB_FE]    = fe_q;
        status[SB_BRK]   = brk_q;
        status[SB_ROE]   = roe_q;
        status[SB_TOE]   = toe_q;
        status[SB_TMT]   = tmt;
        status[SB_TRDY]  = trdy;
        status[SB_RRDY]  = rrdy_q;
        status[SB_EXC]   = fe_q | brk_q | roe_q | toe_q;
        status[SB_DCTS]  = dcts_q;
        status[SB_CTS]   = cts_s;
        status[SB_EOP]   = 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        case (word)
            RG_RXD:  bus_rdata[7:0]       = rx_data_q;
            RG_STAT: bus_rdata[ST_W-1:0]  = status;
            RG_CTRL: bus_rdata[ST_W-1:0]  = ctrl_q;
            RG_DIV:  bus_rdata[DIV_W-1:0] = div_q;
            RG_EOP:  bus_rdata[EOP_W-1:0] = eop_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq     = |irq_terms(status, ctrl_q);
    assign rts_out = ctrl_q[CB_RTS];

    AST_RRDY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> rrdy_q); // R5
    AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rrdy_q && !rd_rxd) |=> roe_q); // R7
    AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (wr_txd && !trdy) |=> toe_q); // R4
    AST_IDLE_IMPLIES_READY: assert property (@(posedge clk) disable iff (rst)
        tmt |-> trdy); // R3
    AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[CB_TXBRK] |-> !ser_tx); // R12
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q & IRQ_EN_MASK) == '0) |-> !irq); // R11
endmodule

// File: tb/mmio_uart_bench.sv
module mmio_uart_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        ser_rx = 1'b1;
    logic        ser_tx;
    logic        cts_in = 1'b0;
    logic        rts_out;

    int checks = 0;
    int fails  = 0;
    int divv   = 16;

    always #10 clk = ~clk;

    mmio_uart u_mmio_uart (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .ser_rx(ser_rx), .ser_tx(ser_tx), .cts_in(cts_in),
        .rts_out(rts_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act,
                          input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    // called at a negedge, returns at the next negedge
    task automatic bus_write(input int idx, input logic [31:0] d);
        bus_addr  = 5'(idx * 4);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input int idx, output logic [31:0] d);
        bus_addr = 5'(idx * 4);
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        logic [9:0] fr;
        fr = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            ser_rx = fr[i];
            repeat (divv) @(negedge clk);
        end
        ser_rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic get_tx(output logic [7:0] b, output logic stop, output bit seen);
        int n;
        n = 0;
        seen = 1'b0;
        b = '0;
        stop = 1'b0;
        while (ser_tx !== 1'b0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (ser_tx === 1'b0) begin
            seen = 1'b1;
            repeat (divv / 2) @(negedge clk);
            if (ser_tx !== 1'b0) seen = 1'b0;
            for (int i = 0; i < 8; i++) begin
                repeat (divv) @(negedge clk);
                b[i] = ser_tx;
            end
            repeat (divv) @(negedge clk);
            stop = ser_tx;
        end
    endtask

    task automatic tx_one(input logic [7:0] v, input string req);
        logic [7:0] b;
        logic s;
        bit seen;
        bus_write(1, {24'h0, v});
        get_tx(b, s, seen);
        chk_eq(req, {22'h0, seen, s, b}, {22'h0, 1'b1, 1'b1, v});
        repeat (divv) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0] ba, bb;
        logic sa, sb;
        bit ea, eb;
        int quiet;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(2, d); chk_eq("R1 status", d, 32'h060);
        bus_read(3, d); chk_eq("R1 control", d, 32'h0);
        bus_read(4, d); chk_eq("R1 divisor", d, 32'd16);
        chk_eq("R1 line/irq/rts", {29'h0, ser_tx, irq, rts_out}, 32'h4);

        bus_write(4, 32'd8);
        divv = 8;

        // R2 frames for several patterns
        tx_one(8'h00, "R2 tx 00");
        tx_one(8'hFF, "R2 tx FF");
        tx_one(8'hA5, "R2 tx A5");
        tx_one(8'h5A, "R2 tx 5A");
        tx_one(8'h01, "R2 tx 01");
        tx_one(8'h80, "R2 tx 80");

        // R3 / R4 holding register, shifter and overrun
        fork
            begin
                get_tx(ba, sa, ea);
                get_tx(bb, sb, eb);
            end
            begin
                bus_write(1, 32'h3C);
                bus_read(2, d); chk_eq("R3 right after write", d, 32'h000);
                bus_read(2, d); chk_eq("R3 moved to shifter", d, 32'h040);
                bus_write(1, 32'hC7);
                bus_read(2, d); chk_eq("R3 held behind shifter", d, 32'h000);
                bus_write(1, 32'h99);
                bus_read(2, d); chk_eq("R4 tx overrun flags", d, 32'h110);
            end
        join
        chk_eq("R2 first queued frame", {22'h0, ea, sa, ba}, {22'h0, 2'b11, 8'h3C});
        chk_eq("R4 second frame kept", {22'h0, eb, sb, bb}, {22'h0, 2'b11, 8'hC7});
        repeat (2 * divv) @(negedge clk);
        bus_read(2, d); chk_eq("R3 idle after both", d, 32'h170);
        quiet = 1;
        for (int i = 0; i < 12 * divv; i++) begin
            @(negedge clk);
            if (ser_tx !== 1'b1) quiet = 0;
        end
        chk_eq("R4 discarded char not sent", quiet, 1);
        bus_write(2, 32'h0);
        bus_read(2, d); chk_eq("R10 toe cleared", d, 32'h060);

        // R5 / R6 sweep of all byte values
        for (int v = 0; v < 256; v++) begin
            send_rx(8'(v), 1'b1);
            bus_read(2, d); chk_eq("R5 rrdy set", d, 32'h0E0);
            bus_read(0, d); chk_eq("R5 rx data", d, 32'(v));
            bus_read(2, d); chk_eq("R6 rrdy cleared", d, 32'h060);
        end

        // R7 overrun
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        bus_read(2, d); chk_eq("R7 overrun status", d, 32'h1E8);
        bus_read(0, d); chk_eq("R7 newer byte kept", d, 32'h22);
        bus_write(2, 32'h0);

        // R8 framing error
        send_rx(8'h55, 1'b0);
        bus_read(2, d); chk_eq("R8 framing status", d, 32'h1E2);
        bus_read(0, d); chk_eq("R8 byte delivered", d, 32'h55);
        bus_write(2, 32'h0);

        // R9 break, R10 clear keeps rrdy
        send_rx(8'h00, 1'b0);
        bus_read(2, d); chk_eq("R9 break status", d, 32'h1E6);
        bus_write(2, 32'hFFFF);
        bus_read(2, d); chk_eq("R10 sticky cleared rrdy kept", d, 32'h0E0);
        bus_read(0, d);
        bus_read(2, d); chk_eq("R10 after drain", d, 32'h060);

        // R11 interrupt masking
        bus_write(3, 32'h040);
        chk_eq("R11 trdy enabled", {31'h0, irq}, 32'h1);
        bus_write(3, 32'h080);
        chk_eq("R11 rrdy enabled idle", {31'h0, irq}, 32'h0);
        send_rx(8'h6E, 1'b1);
        chk_eq("R11 rrdy raises irq", {31'h0, irq}, 32'h1);
        bus_read(0, d);
        chk_eq("R11 read drops irq", {31'h0, irq}, 32'h0);

        // R13 RTS and CTS
        bus_write(3, 32'h800);
        chk_eq("R13 rts driven", {31'h0, rts_out}, 32'h1);
        bus_read(3, d); chk_eq("R13 control readback", d, 32'h800);
        cts_in = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(2, d); chk_eq("R13 cts level and change", d, 32'hC60);
        chk_eq("R11 rts bit is not an enable", {31'h0, irq}, 32'h0);
        bus_write(3, 32'h400);
        chk_eq("R11 cts change enabled", {31'h0, irq}, 32'h1);
        chk_eq("R13 rts released", {31'h0, rts_out}, 32'h0);
        bus_write(2, 32'h0);
        chk_eq("R10 dcts clear drops irq", {31'h0, irq}, 32'h0);
        bus_read(2, d); chk_eq("R10 cts level kept", d, 32'h860);
        cts_in = 1'b0;
        repeat (4) @(negedge clk);
        bus_write(2, 32'h0);

        // R12 forced break
        bus_write(3, 32'h200);
        chk_eq("R12 break low", {31'h0, ser_tx}, 32'h0);
        chk_eq("R11 break bit is not an enable", {31'h0, irq}, 32'h0);
        repeat (20) @(negedge clk);
        chk_eq("R12 break held", {31'h0, ser_tx}, 32'h0);
        bus_write(3, 32'h0);
        chk_eq("R12 line released", {31'h0, ser_tx}, 32'h1);

        // R14 divisor and end-of-packet register
        bus_write(4, 32'd5);
        divv = 5;
        bus_read(4, d); chk_eq("R14 divisor readback", d, 32'd5);
        tx_one(8'h3C, "R14 tx at divisor 5");
        send_rx(8'hC3, 1'b1);
        bus_read(0, d); chk_eq("R14 rx at divisor 5", d, 32'hC3);
        bus_write(5, 32'hAB);
        bus_read(5, d); chk_eq("R14 eop readback", d, 32'hAB);
        bus_read(2, d); chk_eq("R14 pe and eop zero", d, 32'h060);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule